// File: doc/BRIEF.md
# SPI Multi-Master Bus Fault Guard

This block guards the bus of an SPI controller that shares its wires with other masters. It is used when software has set the controller up as master and has set the select line as an input. In that setup the block watches the select pin. If another master pulls the pin to its active level, the block raises a sticky fault flag, drops the controller into slave mode and turns off every output driver it controls. The bus is then left to the master that claimed it.

When this controller wants to transfer, it drives its own select line to the active level to warn the other masters. The block turns that drive on and makes sure that the select activity it causes itself is never reported as a fault. The select pin passes through a synchronizer. A fault is taken only on a synchronized change from the inactive level to the active level, and the active level can be set high or low. Software clears the flag by writing 1. Master mode comes back only when software turns the master enable off and on again while the flag is clear. Shifting data in and out is handled elsewhere.

Top module: `spi_mm_guard`

## Requirements
- R1: After a synchronous reset, `fault_o`, `master_o`, `sclk_oe_o`, `mosi_oe_o` and `sel_oe_o` are all 0.
- R2: A fault can be raised only while the block is in master mode (`master_o`=1) and `cfg_sel_in_i`=1. A select edge while `cfg_sel_in_i`=0 leaves `fault_o` at 0.
- R3: While armed, a change of `sel_pin_i` from its inactive to its active level sets `fault_o` at the third rising clock edge after the change. A pin that stays at its active level, without an edge, raises no fault.
- R4: At the edge where `fault_o` sets, `master_o` drops to 0.
- R5: While `fault_o`=1, `sclk_oe_o`, `mosi_oe_o` and `sel_oe_o` are all 0.
- R6: With `master_o`=1, `xfer_req_i`=1 sets `sel_oe_o`=1 at the next edge, and `sel_out_o` drives the active level. This master's own select activity raises no fault, either while it drives or in the SYNC_STAGES+1 cycles after it lets go.
- R7: `flag_clr_i`=1 clears `fault_o` at the next edge. If a new fault is detected in the same cycle, the set wins.
- R8: `master_o` becomes 1 only on a 0-to-1 change of `cfg_master_i` while `fault_o`=0. Clearing the flag alone does not restore master mode.
- R9: `cfg_sel_act_high_i` selects the active level: 1 means the active level is high, 0 means it is low. Detection and `sel_out_o` both follow this setting.
- R10: With `cfg_master_i`=0, all output enables stay 0, `xfer_req_i` has no effect, and select edges raise no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master_i | input | 1 | Software master enable |
| cfg_sel_in_i | input | 1 | Select line configured as input (multi-master) |
| cfg_sel_act_high_i | input | 1 | Select active level: 1 high, 0 low |
| sel_pin_i | input | 1 | Raw select pin level |
| xfer_req_i | input | 1 | Request to drive own select for a transfer |
| flag_clr_i | input | 1 | Write-1-to-clear strobe for the fault flag |
| fault_o | output | 1 | Sticky mode-fault flag |
| master_o | output | 1 | Effective mode: 1 master, 0 slave |
| sclk_oe_o | output | 1 | Clock output enable |
| mosi_oe_o | output | 1 | Data-out output enable |
| sel_oe_o | output | 1 | Select output enable |
| sel_out_o | output | 1 | Select level driven when enabled |

## Verification
The bench loops this master's own select drive back onto the pin. If the design took its own assertion, or the trailing synchronizer echo after a one-cycle drive, as a foreign edge, it would fault and fall to slave mode in the middle of a transfer. The bench drives a clear in the same cycle as a detection, which exposes a design that lets the clear win and loses the fault. Other checks show that clearing the flag alone leaves the block in slave mode, and that edges arriving while the select is configured as an output, or while in slave mode, are ignored. Both select polarities are exercised, so a design with a fixed polarity would fault on a release or miss a real take-over.

// File: rtl/spi_mmg_pkg.sv
package spi_mmg_pkg;
  // Map a raw select level to "asserted" under the configured polarity.
  function automatic logic sel_asserted(input logic lvl, input logic act_high);
    return act_high ? lvl : ~lvl;
  endfunction
endpackage

// File: rtl/spi_mmg_sync.sv
module spi_mmg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic act_high_i,
  output logic act_o,
  output logic rise_o
);
  import spi_mmg_pkg::*;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= pin_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  assign act_o = sel_asserted(chain_q[STAGES-1], act_high_i);

  // prev resets to asserted so no edge is seen straight out of reset
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= act_o;
  end

  assign rise_o = act_o & ~prev_q;
endmodule

// File: rtl/spi_mmg_own.sv
module spi_mmg_own #(
  parameter int HOLD = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic drive_req_i,
  output logic own_drive_o,
  output logic busy_o
);
  localparam int CW = $clog2(HOLD + 1);

  logic          drive_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      drive_q <= drive_req_i;
      if (drive_q)             cnt_q <= CW'(HOLD);
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end
  end

  assign own_drive_o = drive_q;
  assign busy_o      = drive_q | (cnt_q != '0);

  // R6
  release_masked_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(drive_q) |-> busy_o);
endmodule

// File: rtl/spi_mm_guard.sv
module spi_mm_guard #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_master_i,
  input  logic cfg_sel_in_i,
  input  logic cfg_sel_act_high_i,
  input  logic sel_pin_i,
  input  logic xfer_req_i,
  input  logic flag_clr_i,
  output logic fault_o,
  output logic master_o,
  output logic sclk_oe_o,
  output logic mosi_oe_o,
  output logic sel_oe_o,
  output logic sel_out_o
);
  localparam int GUARD = SYNC_STAGES + 1;

  logic sel_act, sel_rise, own_drive, own_busy;
  logic fault_q, master_q, cfg_prev_q;
  logic armed, detect, master_d, en_rise;

  spi_mmg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(sel_pin_i), .act_high_i(cfg_sel_act_high_i),
    .act_o(sel_act), .rise_o(sel_rise)
  );

  spi_mmg_own #(.HOLD(GUARD)) u_own (
    .clk(clk), .rst(rst), .drive_req_i(xfer_req_i & master_d),
    .own_drive_o(own_drive), .busy_o(own_busy)
  );

  assign armed   = master_q & cfg_master_i & cfg_sel_in_i & ~own_busy;
  assign detect  = armed & sel_rise;
  assign en_rise = cfg_master_i & ~cfg_prev_q;

  always_comb begin
    master_d = master_q;
    if (detect || !cfg_master_i) master_d = 1'b0;
    else if (en_rise && !fault_q) master_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q    <= 1'b0;
      master_q   <= 1'b0;
      cfg_prev_q <= 1'b0;
    end else begin
      cfg_prev_q <= cfg_master_i;
      master_q   <= master_d;
      if (detect)          fault_q <= 1'b1;
      else if (flag_clr_i) fault_q <= 1'b0;
    end
  end

  assign fault_o   = fault_q;
  assign master_o  = master_q;
  assign sclk_oe_o = master_q;
  assign mosi_oe_o = master_q;
  assign sel_oe_o  = own_drive;
  assign sel_out_o = own_drive ? cfg_sel_act_high_i : ~cfg_sel_act_high_i;

  // R2
  armed_only_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_o) |-> $past(master_o && cfg_sel_in_i));
  // R4
  fault_drops_master_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_o) |-> !master_o);
  // R5
  no_drive_in_fault_chk: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> !(sclk_oe_o || mosi_oe_o || sel_oe_o));
  // R6
  own_not_fault_chk: assert property (@(posedge clk) disable iff (rst)
    sel_oe_o |=> !$rose(fault_o));
  // R7
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_o && flag_clr_i && !detect) |=> !fault_o);
  // R8
  master_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(master_o) |-> ($past(!fault_o) && $past(cfg_master_i)));
endmodule

// File: tb/spi_mm_guard_bench.sv
module spi_mm_guard_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m = 0, si = 0, ah = 0, pin_ext = 1, xr = 0, clr = 0;
  logic fault, master, sclk_oe, mosi_oe, sel_oe, sel_out, pin;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  // select line: own drive wins, otherwise the outside level
  assign pin = sel_oe ? sel_out : pin_ext;

  spi_mm_guard u_spi_mm_guard (
    .clk(clk), .rst(rst), .cfg_master_i(m), .cfg_sel_in_i(si),
    .cfg_sel_act_high_i(ah), .sel_pin_i(pin), .xfer_req_i(xr),
    .flag_clr_i(clr), .fault_o(fault), .master_o(master),
    .sclk_oe_o(sclk_oe), .mosi_oe_o(mosi_oe), .sel_oe_o(sel_oe),
    .sel_out_o(sel_out)
  );

  task automatic chk(input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", what, act, exp);
    end
  endtask

  // {m, si, ah, pin_ext, xr, clr, exp_fault, exp_master, exp_oe, exp_sel_oe}
  localparam logic [9:0] VEC [16] = '{
    10'b1101_00_0110, // R3 master entry, pin idle (active low)
    10'b1101_10_0111, // R6 own drive
    10'b1101_00_0110, // R6 release, no fault
    10'b1100_00_1000, // R3 R4 R5 foreign take-over
    10'b1101_01_0000, // R8 clear alone keeps slave
    10'b0101_00_0000, // R10 disable
    10'b1101_00_0110, // R8 re-enable
    10'b1000_00_0110, // R2 select as output: edge ignored
    10'b1101_00_0110, // R2 back to input, release edge
    10'b0110_00_0000, // R9 switch polarity in slave
    10'b1110_00_0110, // R9 master, active high idle
    10'b1111_00_1000, // R9 active-high take-over
    10'b0110_01_0000, // R7 clear
    10'b1110_00_0110, // R8 re-enter
    10'b1110_10_0111, // R6 R9 own drive active high
    10'b1110_00_0110  // R6 release
  };

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 fault", fault, 0); chk("R1 master", master, 0);
    chk("R1 sclk_oe", sclk_oe, 0); chk("R1 mosi_oe", mosi_oe, 0);
    chk("R1 sel_oe", sel_oe, 0);
    rst = 0;
    for (int i = 0; i < 16; i++) begin
      {m, si, ah, pin_ext, xr, clr} = VEC[i][9:4];
      repeat (4) @(negedge clk);
      chk($sformatf("vec%0d fault", i), fault, VEC[i][3]);
      chk($sformatf("vec%0d master", i), master, VEC[i][2]);
      chk($sformatf("vec%0d sclk_oe", i), sclk_oe, VEC[i][1]);
      chk($sformatf("vec%0d mosi_oe", i), mosi_oe, VEC[i][1]);
      chk($sformatf("vec%0d sel_oe", i), sel_oe, VEC[i][0]);
      if (VEC[i][0]) chk($sformatf("vec%0d R9 sel_out", i), sel_out, ah);
    end
    // R3 timing and R7 set beats clear: active high, master
    pin_ext = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R3 not before third edge", fault, 0);
    clr = 1;
    @(negedge clk); clr = 0;
    chk("R7 set wins over clear", fault, 1);
    chk("R4 master dropped", master, 0);
    // R8 clearing alone keeps slave
    pin_ext = 0; clr = 1; @(negedge clk); clr = 0;
    repeat (3) @(negedge clk);
    chk("R7 cleared", fault, 0);
    chk("R8 still slave", master, 0);
    m = 0; @(negedge clk); m = 1; repeat (2) @(negedge clk);
    chk("R8 re-enabled", master, 1);
    // R6 one-cycle own drive, trailing echo must be masked
    xr = 1; @(negedge clk); xr = 0;
    chk("R6 drive on", sel_oe, 1);
    repeat (6) @(negedge clk);
    chk("R6 short drive no fault", fault, 0);
    chk("R6 short drive stays master", master, 1);
    // R3 steady active level on entry raises no fault
    m = 0; pin_ext = 1; repeat (4) @(negedge clk);
    m = 1; repeat (5) @(negedge clk);
    chk("R3 steady active no fault", fault, 0);
    chk("R3 steady active master", master, 1);
    // R10 slave: request and edges ignored
    m = 0; pin_ext = 0; xr = 1; repeat (3) @(negedge clk);
    chk("R10 sel_oe off", sel_oe, 0); chk("R10 sclk_oe off", sclk_oe, 0);
    pin_ext = 1; repeat (4) @(negedge clk);
    chk("R10 no fault", fault, 0);
    xr = 0; pin_ext = 0;
    // R1 reset while faulted
    m = 1; repeat (3) @(negedge clk);
    pin_ext = 1; repeat (4) @(negedge clk);
    chk("R5 fault before reset", fault, 1);
    chk("R5 oe off", mosi_oe, 0);
    rst = 1; @(negedge clk); @(negedge clk);
    chk("R1 fault after reset", fault, 0);
    chk("R1 master after reset", master, 0);
    chk("R1 sel_oe after reset", sel_oe, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule